// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and reduces them to one interrupt level and one vector number for a processor. Each source has an 8-bit priority byte that software writes over a 32-bit register bus. A nonzero byte enables the source and a zero byte disables it. A 64-bit mask register, which resets to all ones, can block any source. A 64-bit force register can also raise a source. This force register can be loaded only through a dedicated test port.

The controller scans all sources that are active and not masked, and picks the one with the largest priority byte. When two sources share the largest byte, the higher-numbered source wins. The winner's priority byte is driven out as the interrupt level. Its index plus 64 is driven out as the vector. When no source is active, the level is 0 and the vector is the fixed spurious value 24. Software reads the current vector back through an acknowledge register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are level 0 and vector 24. Both mask words read 0xFFFFFFFF. The pending and force words read 0. Every priority byte reads 0.
- R2: The pending register samples the request inputs on every clock, so a bit is 1 while its input is high. Pending bits 63..32 read at offset 0x00 and bits 31..0 at offset 0x04. Bus writes to these two offsets leave the pending register unchanged.
- R3: A source takes part in arbitration only when it is pending or forced, and it is enabled, and its mask bit is 0.
- R4: Among the sources that take part, the one with the largest priority byte wins. The level output equals that byte and the vector output equals the source index plus 64.
- R5: When two or more sources share the largest priority byte, the highest-numbered one wins.
- R6: With no source taking part, the level output is 0 and the vector output is 24.
- R7: Priority bytes for sources 0..63 sit at byte offsets 0x40..0x7F, and a write there takes bits 7..0 of the data. A nonzero byte enables the source and a zero byte disables it. The byte reads back zero-extended.
- R8: A write to offset 0x08 replaces only mask bits 63..32, and a write to offset 0x0C replaces only mask bits 31..0.
- R9: A read of offset 0xE0 returns the current vector. Reads of offsets outside the register map return 0.
- R10: A write to any offset other than 0x08, 0x0C or 0x40..0x7F changes no state. Such a write raises bus_err for exactly the following clock cycle.
- R11: The level and vector outputs change on the first clock edge after a register changes. After a request input changes, they change on the second edge, because the input first passes through the pending register.
- R12: The force register is not writable from the bus. The test port loads it on a clock edge while tst_frc_we is high. Force bits 63..32 read at offset 0x10 and bits 31..0 at offset 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| bus_err | output | 1 | One-cycle strobe after a write to a non-writable offset |
| tst_frc_we | input | 1 | Test port: load the force register |
| tst_frc_val | input | 64 | Test port: value for the force register |
| cpu_level | output | 8 | Priority of the winning source, 0 when idle |
| cpu_vector | output | 8 | Winning index plus 64, or 24 when idle |

## Verification
The hardest situation to reach from the ports is the moment between a state change and its registered effect. One case is a mask write that has already landed while the outputs still show the old winner. The other is an input drop that has reached the pending register but not yet the outputs. The stimulus reaches both by sampling at the falling edge directly after the write edge, and again one cycle later, with a known winner standing before the change. Tie-breaking and extreme indices 0 and 63 come from a vector table that raises two sources with chosen priorities. The force path can only be reached through the test port, so the bench loads force with all request inputs low.

// File: rtl/irq_ctl_pkg.sv
// Shared sizes and register offsets of the prioritized interrupt controller.
// Assumes 64 sources split into two 32-bit words for the wide registers.
package irq_ctl_pkg;
    localparam int unsigned N_SRC     = 64;
    localparam int unsigned PRIO_W    = 8;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned VEC_BASE  = 64;
    localparam int unsigned VEC_SPUR  = 24;

    localparam int unsigned OFS_PEND_HI = 'h00;
    localparam int unsigned OFS_PEND_LO = 'h04;
    localparam int unsigned OFS_MASK_HI = 'h08;
    localparam int unsigned OFS_MASK_LO = 'h0C;
    localparam int unsigned OFS_FRC_HI  = 'h10;
    localparam int unsigned OFS_FRC_LO  = 'h14;
    localparam int unsigned OFS_PRIO    = 'h40;
    localparam int unsigned OFS_ACK     = 'hE0;
endpackage

// File: rtl/irq_ctl_regs.sv
// State of the controller: pending, mask, force, per-source priority and enable.
// Assumes a single-cycle bus write; only mask words and priority bytes are writable.
module irq_ctl_regs
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NS   = N_SRC,
    parameter int unsigned PW   = PRIO_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned AW   = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        irq_src,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 tst_frc_we,
    input  logic [NS-1:0]        tst_frc_val,
    output logic [NS-1:0]        pend_q,
    output logic [NS-1:0]        mask_q,
    output logic [NS-1:0]        frc_q,
    output logic [NS-1:0]        en_q,
    output logic [NS-1:0][PW-1:0] prio_q
);
    localparam logic [AW-1:0] A_MASK_HI = AW'(OFS_MASK_HI);
    localparam logic [AW-1:0] A_MASK_LO = AW'(OFS_MASK_LO);

    logic past_ok;

    // Pending bits follow the request inputs one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_src;
    end

    // Mask words: each bus write replaces only its addressed half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && wr_addr == A_MASK_HI) begin
            mask_q[NS-1:DW] <= wr_data;
        end else if (wr_en && wr_addr == A_MASK_LO) begin
            mask_q[DW-1:0] <= wr_data;
        end
    end

    // Force register is loaded only through the test port.
    always_ff @(posedge clk) begin
        if (!rst_n)          frc_q <= '0;
        else if (tst_frc_we) frc_q <= tst_frc_val;
    end

    // Marks cycles whose previous cycle was out of reset (for checks only).
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar i = 0; i < NS; i++) begin : g_src
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(OFS_PRIO + i));

        // Priority byte write; its enable tracks whether the byte is nonzero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[i] <= '0;
                en_q[i]   <= 1'b0;
            end else if (hit) begin
                prio_q[i] <= wr_data[PW-1:0];
                en_q[i]   <= (wr_data[PW-1:0] != '0);
            end
        end

        // R7
        enable_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_q[i] == (prio_q[i] != '0));
    end

    // R8
    mask_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && wr_en && wr_addr == A_MASK_HI |=> $stable(mask_q[DW-1:0]));
endmodule

// File: rtl/irq_ctl_arb.sv
// Priority arbitration over all sources with a registered level/vector result.
// Assumes enabled sources carry nonzero priority; ties go to the higher index.
module irq_ctl_arb
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NS    = N_SRC,
    parameter int unsigned PW    = PRIO_W,
    parameter int unsigned VW    = VEC_W,
    parameter int unsigned VBASE = VEC_BASE,
    parameter int unsigned VSPUR = VEC_SPUR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NS-1:0]         pend_q,
    input  logic [NS-1:0]         frc_q,
    input  logic [NS-1:0]         en_q,
    input  logic [NS-1:0]         mask_q,
    input  logic [NS-1:0][PW-1:0] prio_q,
    output logic [PW-1:0]         level_q,
    output logic [VW-1:0]         vec_q
);
    localparam int unsigned IDX_W = $clog2(NS);

    logic [NS-1:0]    active;
    logic [PW-1:0]    best_lvl;
    logic [IDX_W-1:0] best_idx;
    logic             found;
    logic [VW-1:0]    vec_d;
    logic [NS-1:0]    act_prev;
    logic             past_ok;

    for (genvar i = 0; i < NS; i++) begin : g_act
        // A source competes when requested, enabled and unmasked.
        assign active[i] = (pend_q[i] | frc_q[i]) & en_q[i] & ~mask_q[i];
    end

    // Ascending scan with >= so the highest index wins a tie.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (active[i] && prio_q[i] >= best_lvl) begin
                best_lvl = prio_q[i];
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        vec_d = found ? (VW'(VBASE) + VW'(best_idx)) : VW'(VSPUR);
    end

    // Register the arbitration result for the processor side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            vec_q   <= VW'(VSPUR);
        end else begin
            level_q <= found ? best_lvl : '0;
            vec_q   <= vec_d;
        end
    end

    // Copy of the previous active set, used by the check below only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prev <= '0;
            past_ok  <= 1'b0;
        end else begin
            act_prev <= active;
            past_ok  <= 1'b1;
        end
    end

    // R4
    winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && level_q != '0 |-> act_prev[vec_q[IDX_W-1:0]]);
endmodule

// File: rtl/irq_ctl_bus.sv
// Read multiplexer and bad-write error strobe of the register bus.
// Assumes combinational read data and one access per cycle.
module irq_ctl_bus
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NS = N_SRC,
    parameter int unsigned PW = PRIO_W,
    parameter int unsigned VW = VEC_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [NS-1:0]         pend_q,
    input  logic [NS-1:0]         mask_q,
    input  logic [NS-1:0]         frc_q,
    input  logic [NS-1:0][PW-1:0] prio_q,
    input  logic [VW-1:0]         vec_q,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_err
);
    localparam int unsigned IDX_W = $clog2(NS);

    logic in_prio;
    logic bad_wr;
    logic past_ok;

    assign in_prio = (bus_addr >= AW'(OFS_PRIO)) && (bus_addr < AW'(OFS_PRIO + NS));

    // Select read data by offset; nothing is driven outside a read.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (in_prio) begin
                bus_rdata = DW'(prio_q[bus_addr[IDX_W-1:0]]);
            end else begin
                case (bus_addr)
                    AW'(OFS_PEND_HI): bus_rdata = pend_q[NS-1:DW];
                    AW'(OFS_PEND_LO): bus_rdata = pend_q[DW-1:0];
                    AW'(OFS_MASK_HI): bus_rdata = mask_q[NS-1:DW];
                    AW'(OFS_MASK_LO): bus_rdata = mask_q[DW-1:0];
                    AW'(OFS_FRC_HI):  bus_rdata = frc_q[NS-1:DW];
                    AW'(OFS_FRC_LO):  bus_rdata = frc_q[DW-1:0];
                    AW'(OFS_ACK):     bus_rdata = DW'(vec_q);
                    default:          bus_rdata = '0;
                endcase
            end
        end
    end

    assign bad_wr = bus_sel && bus_wr && !in_prio &&
                    (bus_addr != AW'(OFS_MASK_HI)) && (bus_addr != AW'(OFS_MASK_LO));

    // One-cycle error strobe after a write to a non-writable offset.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bad_wr;
    end

    // Marks cycles whose previous cycle was out of reset (for checks only).
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && bus_err |-> $past(bus_sel && bus_wr));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the prioritized 64-source interrupt controller.
// Assumes a synchronous active-low reset and a single clock domain.
module prio_irq_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NS    = N_SRC,
    parameter int unsigned PW    = PRIO_W,
    parameter int unsigned VW    = VEC_W,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned VBASE = VEC_BASE,
    parameter int unsigned VSPUR = VEC_SPUR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] irq_src,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    input  logic          tst_frc_we,
    input  logic [NS-1:0] tst_frc_val,
    output logic [PW-1:0] cpu_level,
    output logic [VW-1:0] cpu_vector
);
    logic [NS-1:0]         pend_q;
    logic [NS-1:0]         mask_q;
    logic [NS-1:0]         frc_q;
    logic [NS-1:0]         en_q;
    logic [NS-1:0][PW-1:0] prio_q;

    irq_ctl_regs #(.NS(NS), .PW(PW), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src    (irq_src),
        .wr_en      (bus_sel && bus_wr),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .tst_frc_we (tst_frc_we),
        .tst_frc_val(tst_frc_val),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .frc_q      (frc_q),
        .en_q       (en_q),
        .prio_q     (prio_q)
    );

    irq_ctl_arb #(.NS(NS), .PW(PW), .VW(VW), .VBASE(VBASE), .VSPUR(VSPUR)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_q (pend_q),
        .frc_q  (frc_q),
        .en_q   (en_q),
        .mask_q (mask_q),
        .prio_q (prio_q),
        .level_q(cpu_level),
        .vec_q  (cpu_vector)
    );

    irq_ctl_bus #(.NS(NS), .PW(PW), .VW(VW), .DW(DW), .AW(AW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .frc_q    (frc_q),
        .prio_q   (prio_q),
        .vec_q    (cpu_vector),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err)
    );

    // R6
    idle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == '0) == (cpu_vector == VW'(VSPUR)));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_TV = 6;
    // {source a, prio a, source b, prio b, expected level, expected vector}
    localparam int TV [N_TV][6] = '{
        '{ 3,   5, 10,   2,   5,  67},
        '{ 3,   4, 10,   4,   4,  74},
        '{63,   7,  0,   7,   7, 127},
        '{ 0,   1,  1,   0,   1,  64},
        '{20, 255, 21, 254, 255,  84},
        '{ 5,   0,  6,   0,   0,  24}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] irq_src = '0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        tst_frc_we = 0;
    logic [63:0] tst_frc_val = '0;
    logic [7:0]  cpu_level, cpu_vector;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    prio_irq_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 level", cpu_level, 0);
        check("R1 vector", cpu_vector, 24);
        bus_read(8'h08, rd); check("R1 mask hi", rd, 32'hFFFFFFFF);
        bus_read(8'h0C, rd); check("R1 mask lo", rd, 32'hFFFFFFFF);
        bus_read(8'h04, rd); check("R1 pending lo", rd, 0);
        bus_read(8'h10, rd); check("R1 force hi", rd, 0);
        bus_read(8'h7F, rd); check("R1 prio 63", rd, 0);

        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h0);

        // R4 R5 R6 R7: vector table
        for (int k = 0; k < N_TV; k++) begin
            bus_write(8'(8'h40 + TV[k][0]), 32'(TV[k][1]));
            bus_write(8'(8'h40 + TV[k][2]), 32'(TV[k][3]));
            irq_src = (64'd1 << TV[k][0]) | (64'd1 << TV[k][2]);
            repeat (3) @(negedge clk);
            check($sformatf("R4/R5/R6 row %0d level", k), cpu_level, 64'(TV[k][4]));
            check($sformatf("R4/R5/R6 row %0d vector", k), cpu_vector, 64'(TV[k][5]));
            bus_write(8'(8'h40 + TV[k][0]), 32'h0);
            bus_write(8'(8'h40 + TV[k][2]), 32'h0);
            irq_src = '0;
        end
        repeat (2) @(negedge clk);
        check("R6 idle vector", cpu_vector, 24);

        // R7 priority readback
        bus_write(8'h54, 32'h1234_56A5);
        bus_read(8'h54, rd); check("R7 prio readback", rd, 32'hA5);
        bus_write(8'h54, 32'h0);

        // R3 R11 mask timing
        bus_write(8'h49, 32'd3);
        irq_src = 64'd1 << 9;
        repeat (3) @(negedge clk);
        check("R4 source 9 level", cpu_level, 3);
        bus_write(8'h0C, 32'h200);
        check("R11 old level kept one edge", cpu_level, 3);
        @(negedge clk);
        check("R3 masked level", cpu_level, 0);
        check("R3 masked vector", cpu_vector, 24);
        bus_read(8'h0C, rd); check("R8 mask lo", rd, 32'h200);
        bus_write(8'h08, 32'hFFFF0000);
        bus_read(8'h0C, rd); check("R8 lo kept after hi write", rd, 32'h200);
        bus_read(8'h08, rd); check("R8 mask hi", rd, 32'hFFFF0000);
        bus_write(8'h0C, 32'h0);
        repeat (2) @(negedge clk);
        check("R3 unmasked vector", cpu_vector, 73);
        @(negedge clk); irq_src = '0;
        @(negedge clk);
        check("R11 input drop, one edge", cpu_level, 3);
        @(negedge clk);
        check("R11 input drop, two edges", cpu_level, 0);
        bus_write(8'h49, 32'h0);

        // R2 R10 pending follows inputs, writes ignored
        irq_src = 64'h8000_0001_0000_0004;
        @(negedge clk);
        bus_read(8'h00, rd); check("R2 pending hi", rd, 32'h80000001);
        bus_read(8'h04, rd); check("R2 pending lo", rd, 32'h4);
        bus_write(8'h00, 32'h0);
        check("R10 err on pending write", bus_err, 1);
        bus_read(8'h00, rd); check("R2 pending write ignored", rd, 32'h80000001);
        check("R10 err one cycle", bus_err, 0);
        bus_write(8'h0C, 32'h0);
        check("R10 no err on mask write", bus_err, 0);
        irq_src = '0;
        bus_write(8'h20, 32'hFFFF);
        check("R10 err on unlisted write", bus_err, 1);
        bus_read(8'h20, rd); check("R9 unlisted read", rd, 0);
        bus_read(8'hE1, rd); check("R9 unlisted read E1", rd, 0);

        // R12 force through test port
        bus_write(8'h47, 32'd3);
        @(negedge clk); tst_frc_we = 1; tst_frc_val = 64'h80;
        @(negedge clk); tst_frc_we = 0; tst_frc_val = '0;
        @(negedge clk);
        check("R12 forced level", cpu_level, 3);
        check("R12 forced vector", cpu_vector, 71);
        bus_read(8'hE0, rd); check("R9 ack read", rd, 71);
        bus_read(8'h14, rd); check("R12 force lo", rd, 32'h80);
        bus_write(8'h14, 32'h0);
        check("R10 err on force write", bus_err, 1);
        bus_read(8'h14, rd); check("R12 force not bus writable", rd, 32'h80);
        bus_write(8'hE0, 32'h0);
        bus_read(8'hE0, rd); check("R10 ack write ignored", rd, 71);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule